// File: doc/BRIEF.md
# Adaptive Impulse Blanker for Complex Sample Streams

This block strips short, strong bursts such as radar pulses out of a stream of complex baseband samples. It tracks the power of the incoming samples with exponential estimates of mean and variance. A sample whose power stands far enough above the mean, measured in standard deviations, counts as a pulse. Samples travel through a fixed delay line before they leave the block, so the blanker can zero samples that came before the detected one as well as samples that follow it.

Detection examines one sample in every four. The precursor, which reaches back before the trigger, covers the samples in between and the detection pipeline. Several blanking timers run side by side, so a pulse that arrives while a window is still open starts another blanking event. A small write-only register port sets the threshold multiplier, the window length and the precursor length. The pipeline advances only on accepted input samples, so gaps in the input valid strobe do not change the result.

Top module: `pulse_blanker`

## Requirements
- R1: During and after reset, out_valid, out_blank, out_i and out_q are 0. The configuration defaults are threshold 5, window 16 and precursor 4.
- R2: The delay is D = PRE_MAX + 3 accepted samples (11 by default). Each accepted input sample with index n >= D produces exactly one output in the next cycle, carrying sample n - D. Samples with index below D produce no output. An output that is not blanked carries that sample unchanged.
- R3: Power is p = i*i + q*q. Only decimated samples (index a multiple of 4) update the statistics: mean += (p - mean) >>> 3 and var += ((p - mean)^2 - var) >>> 3. Both updates are arithmetic, with floor rounding, and start from 0 at reset.
- R4: A decimated sample is a pulse when three conditions hold: at least 8 statistics updates have already occurred, p > mean, and (p - mean)^2 > b*b*var, where b is the threshold.
- R5: A pulse at index t blanks every output index j with t - P <= j <= t + W - 1, where P is the precursor and W is the window. A blanked output has out_blank = 1 and out_i = out_q = 0.
- R6: A precursor write above PRE_MAX (8) is stored as PRE_MAX.
- R7: A sample detected as a pulse leaves the mean and variance unchanged.
- R8: Each detection takes a free timer. When all NT (2) timers are busy, the timer whose window ends last is pushed out to the new window's end. Overlapping pulses therefore blank the union of their windows.
- R9: Samples whose index is not a multiple of 4 never trigger blanking, whatever their power.
- R10: Register address 0 holds the threshold (low 8 bits of write data), address 1 the window length (16 bits), and address 2 the precursor length. Address 3 is ignored. A write acts on every detection that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 8 | In-phase sample, signed |
| in_q | input | 8 | Quadrature sample, signed |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 8 | Delayed in-phase sample, zero when blanked |
| out_q | output | 8 | Delayed quadrature sample, zero when blanked |
| out_blank | output | 1 | The current output sample was blanked |

## Verification
The assertions check, on every cycle, that blanked outputs carry zero data and that outputs only follow accepted inputs. They also check that a detection leaves the mean unchanged, that a detection leaves a timer busy, and that no timer waits longer than the precursor bound. Which samples become pulses, and where each blanking window starts and ends, depend on the arithmetic history of the statistics. Only the bench's scenarios can show these. The bench replays each stream through its own model of the estimator and compares every output sample and blank flag against it.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    SEL_THRESH    = 2'd0,
    SEL_WINDOW    = 2'd1,
    SEL_PRECURSOR = 2'd2,
    SEL_NONE      = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pb_delay_line.sv
module pb_delay_line #(
  parameter int SW    = 8,
  parameter int DEPTH = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [SW-1:0] din_i,
  input  logic signed [SW-1:0] din_q,
  output logic signed [SW-1:0] dout_i,
  output logic signed [SW-1:0] dout_q,
  output logic                 full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [2*SW-1:0] mem [DEPTH];
  logic [AW-1:0]   wptr;
  logic [FW-1:0]   fill;
  logic [2*SW-1:0] rd;

  // the slot about to be overwritten holds the sample DEPTH steps old
  assign rd     = mem[wptr];
  assign dout_i = $signed(rd[2*SW-1:SW]);
  assign dout_q = $signed(rd[SW-1:0]);
  assign full   = (fill == FW'(DEPTH));

  always_ff @(posedge clk) begin
    if (step) mem[wptr] <= {din_i, din_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else if (step) begin
      wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (!full) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/pb_stats_detect.sv
module pb_stats_detect #(
  parameter int SW    = 8,
  parameter int TH_W  = 8,
  parameter int DEC   = 4,
  parameter int SHIFT = 3,
  parameter int WARM  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  input  logic [TH_W-1:0]      thresh,
  output logic                 det_hit,
  output logic [2*SW-1:0]      mean_out
);
  localparam int PW  = 2 * SW;
  localparam int QW  = 2 * PW;
  localparam int LW  = QW + 2 * TH_W;
  localparam int PHW = (DEC > 1) ? $clog2(DEC) : 1;
  localparam int WCW = $clog2(WARM + 1);

  function automatic logic [PW-1:0] power_of(logic signed [SW-1:0] a, logic signed [SW-1:0] b);
    logic signed [PW-1:0] aa;
    logic signed [PW-1:0] bb;
    aa = a * a;
    bb = b * b;
    return $unsigned(aa) + $unsigned(bb);
  endfunction

  function automatic logic [PW-1:0] mean_step(logic [PW-1:0] cur, logic [PW-1:0] tgt);
    logic signed [PW+1:0] c;
    logic signed [PW+1:0] dl;
    c  = $signed({2'b00, cur});
    dl = $signed({2'b00, tgt}) - c;
    return PW'(c + (dl >>> SHIFT));
  endfunction

  function automatic logic [QW-1:0] var_step(logic [QW-1:0] cur, logic [QW-1:0] tgt);
    logic signed [QW+1:0] c;
    logic signed [QW+1:0] dl;
    c  = $signed({2'b00, cur});
    dl = $signed({2'b00, tgt}) - c;
    return QW'(c + (dl >>> SHIFT));
  endfunction

  function automatic logic over_limit(logic [QW-1:0] dsq, logic [QW-1:0] vr, logic [TH_W-1:0] b);
    logic [2*TH_W-1:0] b2;
    logic [LW-1:0]     lim;
    b2  = b * b;
    lim = {{(2*TH_W){1'b0}}, vr} * {{QW{1'b0}}, b2};
    return {{(2*TH_W){1'b0}}, dsq} > lim;
  endfunction

  logic [PHW-1:0] phase;
  logic [PW-1:0]  s1_p;
  logic           s1_dec;
  logic [QW-1:0]  s2_dsq;
  logic           s2_pos;
  logic           s2_dec;
  logic [PW-1:0]  mean_q;
  logic [QW-1:0]  var_q;
  logic [WCW-1:0] warm_cnt;
  logic           warm_ok;

  logic signed [PW:0] d1;
  logic [PW-1:0]      mag1;

  assign d1       = $signed({1'b0, s1_p}) - $signed({1'b0, mean_q});
  assign mag1     = d1[PW] ? PW'(-d1) : PW'(d1);
  assign warm_ok  = (warm_cnt == WCW'(WARM));
  assign det_hit  = step && s2_dec && warm_ok && s2_pos && over_limit(s2_dsq, var_q, thresh);
  assign mean_out = mean_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      s1_p     <= '0;
      s1_dec   <= 1'b0;
      s2_dsq   <= '0;
      s2_pos   <= 1'b0;
      s2_dec   <= 1'b0;
      mean_q   <= '0;
      var_q    <= '0;
      warm_cnt <= '0;
    end else if (step) begin
      phase  <= phase + 1'b1;
      s1_p   <= power_of(in_i, in_q);
      s1_dec <= (phase == '0);
      s2_dsq <= QW'(mag1) * QW'(mag1);
      s2_pos <= !d1[PW] && (d1 != '0);
      s2_dec <= s1_dec;
      if (s2_dec && !det_hit) begin
        mean_q <= mean_step(mean_q, s1_p_d);
        var_q  <= var_step(var_q, s2_dsq);
        if (!warm_ok) warm_cnt <= warm_cnt + 1'b1;
      end
    end
  end

  // power of the sample held in stage two
  logic [PW-1:0] s1_p_d;
  always_ff @(posedge clk) begin
    if (!rst_n)    s1_p_d <= '0;
    else if (step) s1_p_d <= s1_p;
  end
endmodule

// File: rtl/pb_timer_bank.sv
module pb_timer_bank #(
  parameter int NT      = 2,
  parameter int CW      = 17,
  parameter int PRE_MAX = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            load,
  input  logic [CW-1:0]   pre_len,
  input  logic [CW-1:0]   win_len,
  output logic            blank,
  output logic            any_busy,
  output logic [NT*CW-1:0] wait_flat
);
  localparam int IW = (NT > 1) ? $clog2(NT) : 1;

  logic [CW-1:0] wt [NT];
  logic [CW-1:0] rm [NT];
  logic [NT-1:0] busy;
  logic [NT-1:0] active;
  logic [CW-1:0] start_gap;
  logic [CW-1:0] len;
  logic [CW-1:0] total;
  logic          load_ok;
  logic          any_free;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] late_idx;
  logic [CW:0]   late_end;

  assign start_gap = CW'(PRE_MAX) - pre_len;
  assign len       = pre_len + win_len;
  assign total     = CW'(PRE_MAX) + win_len;
  assign load_ok   = load && (len != '0);
  assign blank     = |active;
  assign any_busy  = |busy;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    late_idx = '0;
    late_end = '0;
    for (int j = 0; j < NT; j++) begin
      if (!busy[j] && !any_free) begin
        any_free = 1'b1;
        free_idx = IW'(j);
      end
      if (busy[j] && (({1'b0, wt[j]} + {1'b0, rm[j]}) > late_end)) begin
        late_end = {1'b0, wt[j]} + {1'b0, rm[j]};
        late_idx = IW'(j);
      end
    end
  end

  for (genvar j = 0; j < NT; j++) begin : g_tmr
    logic [CW-1:0] nwait;
    logic [CW-1:0] nrem;
    logic          pick_new;
    logic          pick_ext;

    assign busy[j]   = (rm[j] != '0);
    assign active[j] = busy[j] && (wt[j] == '0);
    assign nwait     = (wt[j] != '0) ? wt[j] - 1'b1 : wt[j];
    assign nrem      = active[j] ? rm[j] - 1'b1 : rm[j];
    assign pick_new  = load_ok && any_free && (free_idx == IW'(j));
    assign pick_ext  = load_ok && !any_free && (late_idx == IW'(j));
    assign wait_flat[j*CW +: CW] = wt[j];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wt[j] <= '0;
        rm[j] <= '0;
      end else if (step) begin
        if (pick_new) begin
          wt[j] <= start_gap;
          rm[j] <= len;
        end else if (pick_ext) begin
          wt[j] <= nwait;
          rm[j] <= total - nwait;
        end else begin
          wt[j] <= nwait;
          rm[j] <= nrem;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_blanker.sv
module pulse_blanker
  import pb_pkg::*;
#(
  parameter int SW        = 8,
  parameter int TH_W      = 8,
  parameter int WIN_W     = 16,
  parameter int PRE_MAX   = 8,
  parameter int NT        = 2,
  parameter int DEC       = 4,
  parameter int EMA_SHIFT = 3,
  parameter int WARM      = 8,
  parameter int DEF_TH    = 5,
  parameter int DEF_WIN   = 16,
  parameter int DEF_PRE   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [WIN_W-1:0]     cfg_wdata,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q,
  output logic                 out_blank
);
  localparam int LAT   = 2;
  localparam int DEPTH = PRE_MAX + LAT + 1;
  localparam int PW    = 2 * SW;
  localparam int CW    = $clog2(PRE_MAX + (1 << WIN_W) + 1);
  localparam int PRW   = $clog2(PRE_MAX + 1);

  logic [TH_W-1:0]  thr_q;
  logic [WIN_W-1:0] win_q;
  logic [PRW-1:0]   pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= TH_W'(DEF_TH);
      win_q <= WIN_W'(DEF_WIN);
      pre_q <= PRW'(DEF_PRE);
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_addr))
        SEL_THRESH:    thr_q <= cfg_wdata[TH_W-1:0];
        SEL_WINDOW:    win_q <= cfg_wdata;
        SEL_PRECURSOR: pre_q <= (cfg_wdata > WIN_W'(PRE_MAX)) ? PRW'(PRE_MAX) : cfg_wdata[PRW-1:0];
        default: ;
      endcase
    end
  end

  logic signed [SW-1:0] dly_i;
  logic signed [SW-1:0] dly_q;
  logic                 dly_full;
  logic                 det_hit;
  logic [PW-1:0]        stat_mean;
  logic                 blank_now;
  logic                 any_busy;
  logic [NT*CW-1:0]     wait_flat;

  pb_delay_line #(.SW(SW), .DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst_n(rst_n), .step(in_valid),
    .din_i(in_i), .din_q(in_q),
    .dout_i(dly_i), .dout_q(dly_q), .full(dly_full)
  );

  pb_stats_detect #(.SW(SW), .TH_W(TH_W), .DEC(DEC), .SHIFT(EMA_SHIFT), .WARM(WARM)) u_stats (
    .clk(clk), .rst_n(rst_n), .step(in_valid),
    .in_i(in_i), .in_q(in_q), .thresh(thr_q),
    .det_hit(det_hit), .mean_out(stat_mean)
  );

  pb_timer_bank #(.NT(NT), .CW(CW), .PRE_MAX(PRE_MAX)) u_timers (
    .clk(clk), .rst_n(rst_n), .step(in_valid), .load(det_hit),
    .pre_len(CW'(pre_q)), .win_len(CW'(win_q)),
    .blank(blank_now), .any_busy(any_busy), .wait_flat(wait_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      out_blank <= 1'b0;
    end else begin
      out_valid <= in_valid && dly_full;
      if (in_valid && dly_full) begin
        out_i     <= blank_now ? '0 : dly_i;
        out_q     <= blank_now ? '0 : dly_q;
        out_blank <= blank_now;
      end
    end
  end
endmodule

// File: rtl/pb_checks.sv
module pb_checks #(
  parameter int SW      = 8,
  parameter int PW      = 16,
  parameter int WIN_W   = 16,
  parameter int NT      = 2,
  parameter int CW      = 17,
  parameter int PRE_MAX = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic                  out_blank,
  input logic signed [SW-1:0]  out_i,
  input logic signed [SW-1:0]  out_q,
  input logic                  det_hit,
  input logic [PW-1:0]         stat_mean,
  input logic                  any_busy,
  input logic [WIN_W-1:0]      win_q,
  input logic [NT*CW-1:0]      wait_flat
);
  assert_blank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_blank) |-> (out_i == '0 && out_q == '0))
    else $error("blanked output carries data");

  assert_out_follows_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid))
    else $error("output without an accepted input");

  assert_stats_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    det_hit |=> $stable(stat_mean))
    else $error("pulse sample moved the mean");

  assert_timer_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_hit && win_q != '0) |=> any_busy)
    else $error("detection left every timer idle");

  for (genvar j = 0; j < NT; j++) begin : g_wait
    assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wait_flat[j*CW +: CW] <= CW'(PRE_MAX))
      else $error("timer start delay beyond precursor bound");
  end
endmodule

bind pulse_blanker pb_checks #(
  .SW(SW), .PW(PW), .WIN_W(WIN_W), .NT(NT), .CW(CW), .PRE_MAX(PRE_MAX)
) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_blank(out_blank), .out_i(out_i), .out_q(out_q), .det_hit(det_hit),
  .stat_mean(stat_mean), .any_busy(any_busy), .win_q(win_q), .wait_flat(wait_flat)
);

// File: tb/pulse_blanker_test.sv
module pulse_blanker_test;
  localparam int PRE_MAX = 8;
  localparam int D       = PRE_MAX + 3;
  localparam int WARM    = 8;
  localparam int MAXN    = 400;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_i = '0;
  logic signed [7:0] in_q = '0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [15:0]       cfg_wdata = '0;
  logic              out_valid;
  logic signed [7:0] out_i;
  logic signed [7:0] out_q;
  logic              out_blank;

  pulse_blanker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_blank(out_blank)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int si [MAXN];
  int sq [MAXN];
  bit trig [MAXN];
  bit expb [MAXN];
  int nsamp;
  int out_idx;
  int blank_seen;
  bit mon_en = 1'b0;
  string tag;
  logic [31:0] rng = 32'h1234_5677;

  function automatic int noise();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return int'(rng % 32'd41) - 20;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output monitor: every emitted sample against the model
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      if (out_idx >= nsamp - D) begin
        check(1'b0, "R2", "extra output index", out_idx, nsamp - D - 1);
      end else begin
        int ei, eq;
        ei = expb[out_idx] ? 0 : si[out_idx];
        eq = expb[out_idx] ? 0 : sq[out_idx];
        check(int'(out_i) == ei && int'(out_q) == eq, expb[out_idx] ? "R5" : "R2",
              $sformatf("%s data idx %0d", tag, out_idx), int'(out_i) * 1000 + int'(out_q), ei * 1000 + eq);
        check(out_blank == expb[out_idx], tag, $sformatf("blank flag idx %0d", out_idx),
              int'(out_blank), int'(expb[out_idx]));
        if (out_blank) blank_seen++;
      end
      out_idx++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset
    check(!out_valid && !out_blank && out_i == 0 && out_q == 0, "R1", "reset outputs",
          int'(out_valid) + int'(out_blank) + int'(out_i != 0), 0);
  endtask

  task automatic cfg_write(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 2'(addr);
    cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic build(int n, int p0s, int p0l, int p1s, int p1l, int amp);
    nsamp = n;
    for (int k = 0; k < n; k++) begin
      if ((k >= p0s && k < p0s + p0l) || (k >= p1s && k < p1s + p1l)) begin
        si[k] = amp;
        sq[k] = amp;
      end else begin
        si[k] = noise();
        sq[k] = noise();
      end
    end
  endtask

  // independent model of the estimator and the blanking windows
  task automatic model(int thr, int win, int pre);
    longint mean, vr, p, d, dsq;
    int warm, pe;
    mean = 0; vr = 0; warm = 0;
    pe = (pre > PRE_MAX) ? PRE_MAX : pre;          // R6
    for (int k = 0; k < nsamp; k++) begin
      trig[k] = 1'b0;
      p = longint'(si[k] * si[k] + sq[k] * sq[k]);  // R3
      if (k % 4 == 0) begin                        // R9: only decimated samples
        d = p - mean;
        dsq = d * d;
        if (warm >= WARM && d > 0 && dsq > longint'(thr * thr) * vr) begin
          trig[k] = 1'b1;                          // R4; R7: no update
        end else begin
          mean = mean + (d >>> 3);
          vr = vr + ((dsq - vr) >>> 3);
          if (warm < WARM) warm++;
        end
      end
    end
    for (int j = 0; j < nsamp - D; j++) begin
      expb[j] = 1'b0;
      for (int t = 0; t < nsamp; t++)
        if (trig[t] && j >= t - pe && j <= t + win - 1) expb[j] = 1'b1;
    end
  endtask

  task automatic drive(bit gaps);
    for (int k = 0; k < nsamp; k++) begin
      if (gaps && (k % 3 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_i = 8'(si[k]);
      in_q = 8'(sq[k]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic scenario(string t, int n, bit gaps, int thr, int win, int pre_wr, int pre_eff,
                          int p0s, int p0l, int p1s, int p1l);
    int nb;
    do_reset();
    if (thr != 5) cfg_write(0, thr);
    cfg_write(1, win);
    cfg_write(2, pre_wr);
    cfg_write(3, 16'hFFFF);                        // R10: ignored address
    tag = t;
    build(n, p0s, p0l, p1s, p1l, 100);
    model(thr, win, pre_eff);
    out_idx = 0;
    blank_seen = 0;
    mon_en = 1'b1;
    drive(gaps);
    mon_en = 1'b0;
    check(out_idx == n - D, "R2", $sformatf("%s output count", t), out_idx, n - D);
    nb = 0;
    for (int j = 0; j < n - D; j++) if (expb[j]) nb++;
    check(blank_seen == nb, t, "blanked sample count", blank_seen, nb);
  endtask

  initial begin
    scenario("R3", 200, 1'b0, 5, 16, 4, 4, 1000, 0, 1000, 0);
    scenario("R4/R5", 300, 1'b1, 5, 8, 4, 4, 100, 6, 1000, 0);
    scenario("R9", 300, 1'b0, 5, 3, 0, 0, 101, 1, 200, 1);
    scenario("R6", 300, 1'b0, 5, 5, 20, 20, 148, 4, 1000, 0);
    scenario("R8/R7", 300, 1'b1, 5, 10, 2, 2, 100, 14, 1000, 0);
    scenario("R10", 300, 1'b0, 255, 8, 4, 4, 120, 8, 1000, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule